// File: doc/BRIEF.md
# Video Timing Controller Host Register Port

This block is the host-facing side of a character-based video timing controller. A host reaches it with three address lines: an active-low chip select, a direction line and a function line. Together they pick one of four operations: load the register index, write the register the index points at, read a status byte, or read the register the index points at. Up to sixteen configuration registers are stored here, each trimmed to its own width on write. Their values go straight out on a flat configuration bus to the counter and address logic that sits beside this block.

Read-back is deliberately selective. Timing registers return zero. Only the start-address and cursor-address pair can be read back. Two indexes report a light-pen address supplied from outside. The unused upper end of the index space returns zero, except that its last slot can be built to return all ones. Two status bits carry events: a light-pen flag that is cleared as a side effect of reading the light-pen address, and a vertical-blank flag that follows the vertical character count. Host transfers complete in a single cycle. There is no valid/ready handshake and no back-pressure, so a host may issue a transfer on any cycle.

Top module: `vtc_host_regs`

## Requirements
- R1: After reset every stored register and the index latch hold 0. The whole configuration bus reads 0, and a data read of index 13 returns 0.
- R2: A write with cs_n=0, rw=0, fsel=0 latches wdata[4:0] as the register index. wdata[7:5] is ignored, so writing 0xED selects index 13.
- R3: A write with cs_n=0, rw=0, fsel=1 stores wdata into the indexed register at the clock edge where wr_stb is high. The new value is visible from the next cycle. A strobe with cs_n=1 changes nothing.
- R4: Stored values are trimmed on write. Indexes 4, 6 and 7 keep 7 bits, indexes 5 and 9 keep 5 bits, indexes 12 and 14 keep 6 bits, and every other stored index keeps 8 bits.
- R5: A data read (cs_n=0, rw=1, fsel=1) of any index from 0 to 11 returns 0x00.
- R6: A data read of indexes 12 to 15 returns the stored, trimmed value.
- R7: A data read of index 16 returns {2'b00, lpen_addr[13:8]} and index 17 returns lpen_addr[7:0]. Writes aimed at 16 or 17 have no effect on either.
- R8: Data reads of indexes 18 to 30 return 0x00. Index 31 returns 0xFF when ALL_ONES_TOP=1 (the default) and 0x00 otherwise.
- R9: A status read (cs_n=0, rw=1, fsel=0) places the light-pen flag on bit 6. The flag sets one cycle after a clock edge where lpen_stb is high. It clears after a data read of index 16 or 17 with rd_stb high. If a set and a clear fall on the same edge, the set wins.
- R10: Status bit 5 becomes 1 one cycle after an edge where vcc >= stored index 6. It stays 1 until an edge where vcc is 0 and vcc is below index 6, and then reads 0. Status bits 7 and 4..0 are always 0.
- R11: rdata is 0x00 whenever cs_n=1 or rw=0.
- R12: cfg[n*8+7:n*8] carries stored register n for n in 0..15, with trimmed bits at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | Direction: 0 write, 1 read |
| fsel | input | 1 | Function line: index/status (0) or register data (1) |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rd_stb | input | 1 | Read strobe, marks a read for side effects |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| lpen_stb | input | 1 | Light-pen strobe pulse |
| lpen_addr | input | 14 | Externally captured light-pen address |
| vcc | input | 7 | Vertical character count from the counters |
| cfg | output | 128 | Stored registers 0..15, 8 bits each |

## Verification
The index latch is driven with bytes whose upper bits are set, and a following write and read then show whether those bits leak into the selection. Data writes of all-ones into every register class show the width trimming on both the configuration bus and the readable indexes. Reads across every index class (write-only, readable, light-pen, reserved, top slot) separate the masking rules from one another. Status sequences that strobe the light pen, read with and without rd_stb, and collide a set with a clear show which event wins. Stepping vcc below, at and above the display height, then back to 0, shows the set and clear of the blank bit.

// File: rtl/vtc_regs_pkg.sv
package vtc_regs_pkg;

  typedef enum logic [1:0] {
    FN_INDEX  = 2'b00,
    FN_WRITE  = 2'b01,
    FN_STATUS = 2'b10,
    FN_READ   = 2'b11
  } host_fn_e;

  // Width trim applied when a value is stored into register n.
  function automatic logic [7:0] store_mask(input int unsigned n);
    case (n)
      4, 6, 7: store_mask = 8'h7F;
      5, 9:    store_mask = 8'h1F;
      12, 14:  store_mask = 8'h3F;
      default: store_mask = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/vtc_host_decode.sv
module vtc_host_decode
  import vtc_regs_pkg::*;
(
  input  logic cs_n,
  input  logic rw,
  input  logic fsel,
  input  logic wr_stb,
  output logic idx_we,
  output logic reg_we,
  output logic stat_rd,
  output logic reg_rd
);

  host_fn_e fn;
  logic     sel;

  assign sel = ~cs_n;
  assign fn  = host_fn_e'({rw, fsel});

  always_comb begin
    idx_we  = 1'b0;
    reg_we  = 1'b0;
    stat_rd = 1'b0;
    reg_rd  = 1'b0;
    if (sel) begin
      case (fn)
        FN_INDEX:  idx_we  = wr_stb;
        FN_WRITE:  reg_we  = wr_stb;
        FN_STATUS: stat_rd = 1'b1;
        FN_READ:   reg_rd  = 1'b1;
        default:   ;
      endcase
    end
  end

  // Decoded functions are mutually exclusive (R11 path relies on this)
  always_comb begin
    p_decode_excl_r11: assert ($countones({idx_we, reg_we, stat_rd, reg_rd}) <= 1);
  end

endmodule

// File: rtl/vtc_reg_file.sv
module vtc_reg_file
  import vtc_regs_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned NSTO  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic               reg_we,
  input  logic [DW-1:0]      wdata,
  output logic [IDX_W-1:0]   idx,
  output logic [NSTO*DW-1:0] cfg_flat
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= wdata[IDX_W-1:0];
  end

  assign idx = idx_q;

  for (genvar g = 0; g < NSTO; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = DW'(store_mask(g));
    logic [DW-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              val_q <= '0;
      else if (reg_we && idx_q == IDX_W'(g))   val_q <= wdata & MASK;
    end

    assign cfg_flat[g*DW +: DW] = val_q;

    // Trimmed bits never become set
    p_trim_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q & ~MASK) == '0);
  end

  p_idx_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> idx == $past(wdata[IDX_W-1:0]));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(cfg_flat));

endmodule

// File: rtl/vtc_status.sv
module vtc_status #(
  parameter int unsigned DW    = 8,
  parameter int unsigned VCC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lpen_stb,
  input  logic             lp_clr,
  input  logic [VCC_W-1:0] vcc,
  input  logic [VCC_W-1:0] vdisp,
  output logic [DW-1:0]    stat
);

  localparam int unsigned LP_BIT = 6;
  localparam int unsigned VB_BIT = 5;

  logic lp_q;
  logic vb_q;
  logic in_blank;

  assign in_blank = (vcc >= vdisp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lp_q <= 1'b0;
    else if (lpen_stb) lp_q <= 1'b1;
    else if (lp_clr)   lp_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                vb_q <= 1'b0;
    else if (in_blank)         vb_q <= 1'b1;
    else if (vcc == '0)        vb_q <= 1'b0;
  end

  always_comb begin
    stat         = '0;
    stat[LP_BIT] = lp_q;
    stat[VB_BIT] = vb_q;
  end

  p_lpen_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lpen_stb |=> stat[LP_BIT]);

  p_lpen_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_clr && !lpen_stb) |=> !stat[LP_BIT]);

  p_vb_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc >= vdisp) |=> stat[VB_BIT]);

  p_vb_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc == '0 && vdisp != '0) |=> !stat[VB_BIT]);

endmodule

// File: rtl/vtc_host_regs.sv
module vtc_host_regs #(
  parameter int unsigned DW           = 8,
  parameter int unsigned IDX_W        = 5,
  parameter int unsigned MA_W         = 14,
  parameter int unsigned VCC_W        = 7,
  parameter bit          ALL_ONES_TOP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rw,
  input  logic             fsel,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             lpen_stb,
  input  logic [MA_W-1:0]  lpen_addr,
  input  logic [VCC_W-1:0] vcc,
  output logic [16*DW-1:0] cfg
);

  localparam int unsigned NSTO    = 16;
  localparam int unsigned RD_LO   = 12;
  localparam int unsigned RD_HI   = 15;
  localparam int unsigned LP_HI   = 16;
  localparam int unsigned LP_LO   = 17;
  localparam int unsigned VDISP_I = 6;
  localparam int unsigned IDX_TOP = (1 << IDX_W) - 1;
  localparam int unsigned HI_PAD  = DW - (MA_W - DW);

  logic             idx_we, reg_we, stat_rd, reg_rd;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    stat;
  logic             lp_clr;

  vtc_host_decode u_decode (
    .cs_n    (cs_n),
    .rw      (rw),
    .fsel    (fsel),
    .wr_stb  (wr_stb),
    .idx_we  (idx_we),
    .reg_we  (reg_we),
    .stat_rd (stat_rd),
    .reg_rd  (reg_rd)
  );

  vtc_reg_file #(.DW(DW), .IDX_W(IDX_W), .NSTO(NSTO)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_we   (idx_we),
    .reg_we   (reg_we),
    .wdata    (wdata),
    .idx      (idx),
    .cfg_flat (cfg)
  );

  assign lp_clr = reg_rd && rd_stb &&
                  (idx == IDX_W'(LP_HI) || idx == IDX_W'(LP_LO));

  vtc_status #(.DW(DW), .VCC_W(VCC_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .lpen_stb (lpen_stb),
    .lp_clr   (lp_clr),
    .vcc      (vcc),
    .vdisp    (cfg[VDISP_I*DW +: VCC_W]),
    .stat     (stat)
  );

  always_comb begin
    rdata = '0;
    if (stat_rd) begin
      rdata = stat;
    end else if (reg_rd) begin
      if (idx >= IDX_W'(RD_LO) && idx <= IDX_W'(RD_HI))
        rdata = cfg[int'(idx)*DW +: DW];
      else if (idx == IDX_W'(LP_HI))
        rdata = {{HI_PAD{1'b0}}, lpen_addr[MA_W-1:DW]};
      else if (idx == IDX_W'(LP_LO))
        rdata = lpen_addr[DW-1:0];
      else if (idx == IDX_W'(IDX_TOP))
        rdata = ALL_ONES_TOP ? '1 : '0;
    end
  end

  p_wo_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rw && fsel && idx < IDX_W'(RD_LO)) |-> rdata == '0);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !rw) |-> rdata == '0);

  p_status_spare_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rw && !fsel) |-> (rdata[7] == 1'b0 && rdata[4:0] == '0));

endmodule

// File: tb/test_vtc_host_regs.sv
module test_vtc_host_regs;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1, rw = 1'b0, fsel = 1'b0;
  logic         wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         lpen_stb = 1'b0;
  logic [13:0]  lpen_addr = 14'h2ABC;
  logic [6:0]   vcc = '0;
  logic [127:0] cfg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vtc_host_regs i_vtc_host_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .fsel(fsel),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata),
    .lpen_stb(lpen_stb), .lpen_addr(lpen_addr), .vcc(vcc), .cfg(cfg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic f, input logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; rw = 1'b0; fsel = f; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic f, input logic stb, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; fsel = f; rd_stb = stb;
    #1 d = rdata;
    @(negedge clk);
    rd_stb = 1'b0; cs_n = 1'b1; rw = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] n, output logic [7:0] d);
    bus_wr(1'b0, n);
    bus_rd(1'b1, 1'b0, d);
  endtask

  task automatic wr_reg(input logic [7:0] n, input logic [7:0] v);
    bus_wr(1'b0, n);
    bus_wr(1'b1, v);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    checks++;
    if (cfg !== '0) begin
      errors++;
      $display("FAIL R1: cfg actual %h expected 0", cfg);
    end
    // index latch is 0: data read first gives index 0 (write-only -> 0)
    bus_rd(1'b1, 1'b0, d);
    chk("R1 idx0 read", d, 8'h00);
    rd_reg(8'd13, d);
    chk("R1 r13", d, 8'h00);
  endtask

  task automatic t_index_write;
    logic [7:0] d;
    bus_wr(1'b0, 8'hED);            // upper bits ignored -> 13
    bus_wr(1'b1, 8'h11);
    chk("R12 cfg r13", cfg[13*8 +: 8], 8'h11);
    bus_rd(1'b1, 1'b0, d);
    chk("R2 r13 via 0xED", d, 8'h11);
    wr_reg(8'd15, 8'h5A);
    rd_reg(8'd15, d);
    chk("R6 r15", d, 8'h5A);
    bus_wr(1'b0, 8'd13);
    bus_wr(1'b1, 8'h99, 1'b1);      // not selected
    bus_rd(1'b1, 1'b0, d);
    chk("R3 cs_n high ignored", d, 8'h11);
  endtask

  task automatic t_trim;
    logic [7:0] d;
    for (int n = 0; n < 16; n++) wr_reg(8'(n), 8'hFF);
    for (int n = 0; n < 16; n++) begin
      logic [7:0] e;
      case (n)
        4, 6, 7: e = 8'h7F;
        5, 9:    e = 8'h1F;
        12, 14:  e = 8'h3F;
        default: e = 8'hFF;
      endcase
      chk($sformatf("R4 cfg r%0d", n), cfg[n*8 +: 8], e);
    end
    rd_reg(8'd12, d); chk("R4 r12 read", d, 8'h3F);
    rd_reg(8'd14, d); chk("R4 r14 read", d, 8'h3F);
    wr_reg(8'd14, 8'hC7);
    rd_reg(8'd14, d); chk("R6 r14", d, 8'h07);
  endtask

  task automatic t_read_classes;
    logic [7:0] d;
    for (int n = 0; n < 12; n++) begin
      rd_reg(8'(n), d);
      chk($sformatf("R5 r%0d", n), d, 8'h00);
    end
    wr_reg(8'd16, 8'h77);
    wr_reg(8'd17, 8'h66);
    rd_reg(8'd16, d); chk("R7 lpen hi", d, 8'h2A);
    rd_reg(8'd17, d); chk("R7 lpen lo", d, 8'hBC);
    for (int n = 18; n < 31; n++) begin
      rd_reg(8'(n), d);
      chk($sformatf("R8 r%0d", n), d, 8'h00);
    end
    rd_reg(8'd31, d); chk("R8 r31", d, 8'hFF);
  endtask

  task automatic t_idle;
    logic [7:0] d;
    bus_wr(1'b0, 8'd31);
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b1; fsel = 1'b1;
    #1 d = rdata;
    chk("R11 cs_n high", d, 8'h00);
    cs_n = 1'b0; rw = 1'b0;
    #1 d = rdata;
    chk("R11 rw low", d, 8'h00);
    cs_n = 1'b1;
  endtask

  task automatic t_vblank;
    logic [7:0] d;
    wr_reg(8'd6, 8'd25);
    @(negedge clk) vcc = 7'd0;
    bus_rd(1'b0, 1'b0, d); chk("R10 vcc 0", d, 8'h00);
    @(negedge clk) vcc = 7'd10;
    bus_rd(1'b0, 1'b0, d); chk("R10 vcc 10", d, 8'h00);
    @(negedge clk) vcc = 7'd25;
    bus_rd(1'b0, 1'b0, d); chk("R10 vcc 25", d, 8'h20);
    @(negedge clk) vcc = 7'd30;
    bus_rd(1'b0, 1'b0, d); chk("R10 vcc 30", d, 8'h20);
    @(negedge clk) vcc = 7'd0;
    bus_rd(1'b0, 1'b0, d); chk("R10 new frame", d, 8'h00);
  endtask

  task automatic t_lpen;
    logic [7:0] d;
    @(negedge clk) lpen_stb = 1'b1;
    @(negedge clk) lpen_stb = 1'b0;
    bus_rd(1'b0, 1'b0, d); chk("R9 set", d, 8'h40);
    bus_wr(1'b0, 8'd17);
    bus_rd(1'b1, 1'b0, d);         // no strobe: no clear
    bus_rd(1'b0, 1'b0, d); chk("R9 no strobe keeps", d, 8'h40);
    bus_wr(1'b0, 8'd12);
    bus_rd(1'b1, 1'b1, d);         // other index: no clear
    bus_rd(1'b0, 1'b0, d); chk("R9 r12 read keeps", d, 8'h40);
    bus_wr(1'b0, 8'd16);
    bus_rd(1'b1, 1'b1, d);
    bus_rd(1'b0, 1'b0, d); chk("R9 cleared by r16", d, 8'h00);
    // collide set and clear on the same edge
    bus_wr(1'b0, 8'd17);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; fsel = 1'b1; rd_stb = 1'b1; lpen_stb = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b0; rd_stb = 1'b0; lpen_stb = 1'b0;
    bus_rd(1'b0, 1'b0, d); chk("R9 set wins", d, 8'h40);
    bus_rd(1'b1, 1'b1, d);
    bus_rd(1'b0, 1'b0, d); chk("R9 cleared by r17", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index_write();
    t_trim();
    t_read_classes();
    t_idle();
    t_vblank();
    t_lpen();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule